// File: doc/BRIEF.md
# Full-Two Parity Codec with Erasure Peeling

This block encodes and repairs words of a degree-two parity code. With G check groups, every data bit joins exactly one unordered pair of groups, and each pair is used once, so the code has G(G-1)/2 data bits. The default G = 6 gives 15 data bits and a 21-bit codeword. The encoder side is purely combinational: it turns a data word into its six check bits.

The decoder side takes a codeword and a mask that flags the positions whose values are unknown (erased). It repairs the word one bit per clock. In each cycle it looks for a group that has exactly one erased member left. The missing value is the XOR of that group's known members, so the decoder fills it in and clears its flag. It stops when nothing is left to repair, or when no group qualifies. In the second case it raises a failure flag and reports the positions it could not resolve. A check-only mode skips the repair and reports the syndrome of the presented word after one clock edge.

Top module: `ft2_codec`

## Requirements
- R1: Codeword layout is data bits at positions [N-1:0] and check bits c0..c(G-1) at positions [N+G-1:N]. Data bit i stands for the pair (a,b), a<b, with the pairs taken in lexicographic order: bit 0 is (0,1), bit 1 is (0,2), bit 14 is (4,5). enc_check[j] is the XOR of every data bit whose pair contains j, and it follows enc_data combinationally.
- R2: Check-only mode (dec_check_only=1 when dec_start is sampled) presents, right after that edge, dec_done=1, dec_fail=0, dec_word_out equal to the input word and dec_unresolved=0. It never raises dec_busy, and the erase mask has no effect.
- R3: dec_syndrome[j] is the XOR of dec_word_out over group j (data bits whose pair contains j, plus check bit cj). A valid codeword gives all zeros.
- R4: Every single-bit and every two-bit corruption of a valid codeword gives a nonzero syndrome in check-only mode.
- R5: In repair mode the values presented at erased positions have no effect on the result.
- R6: Each repair cycle restores exactly one erased bit and leaves every known bit unchanged. The bit restored comes from the lowest-numbered group that holds exactly one erasure.
- R7: When all erasures are resolved, dec_done pulses with dec_fail=0 and dec_word_out holds the complete codeword. For k erasures the pulse appears k+1 cycles after the edge that sampled dec_start.
- R8: When erasures remain and no group holds exactly one, dec_done pulses with dec_fail=1. dec_unresolved then shows the remaining erased positions, and dec_word_out shows the bits restored so far, with unresolved positions reading 0.
- R9: dec_busy is high from the edge that starts a repair until the edge that raises dec_done. dec_start is ignored while busy.
- R10: dec_done lasts one cycle. The results stay held until the next accepted start.
- R11: While rst is high, and right after it, dec_busy, dec_done and dec_fail are 0, and dec_word_out and dec_unresolved are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enc_data | input | N (15) | Data word to encode |
| enc_check | output | G (6) | Check bits of enc_data |
| dec_start | input | 1 | Start a decode operation (sampled when idle) |
| dec_check_only | input | 1 | 1: syndrome only, 0: erasure repair |
| dec_word | input | W (21) | Codeword to decode |
| dec_erase | input | W (21) | 1 marks an erased position |
| dec_busy | output | 1 | Repair in progress |
| dec_done | output | 1 | One-cycle completion pulse |
| dec_fail | output | 1 | Erasure pattern could not be resolved |
| dec_word_out | output | W (21) | Working or final codeword |
| dec_unresolved | output | W (21) | Erased positions still open |
| dec_syndrome | output | G (6) | Syndrome of dec_word_out |

## Verification
A wrong working word or erasure register shows at the ports straight away. dec_word_out and dec_unresolved are the registers themselves, and dec_syndrome is computed directly from them. So a known bit that flips, or a flag that clears without its bit being filled, can be seen in the very cycle after the faulty step. A wrong group choice or a stall first shows as a done pulse that arrives at the wrong cycle count, or as a failure verdict on a pattern that can be peeled. This is why the bench checks the exact latency as well as the final word and the unresolved mask.

// File: rtl/ft2_pkg.sv
package ft2_pkg;

    // Widest codeword the membership helper can describe.
    localparam int MAX_W = 64;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_PEEL = 1'b1
    } dec_state_e;

    typedef struct packed {
        logic found;    // some group holds exactly one erasure
        logic fix_val;  // value recovered for that erasure
    } peel_res_t;

    function automatic int info_bits(input int g);
        return g * (g - 1) / 2;
    endfunction

    // Columns that belong to group j: data bits whose pair holds j, plus check bit j.
    function automatic logic [MAX_W-1:0] group_cols(input int g, input int j);
        logic [MAX_W-1:0] m;
        int idx;
        m   = '0;
        idx = 0;
        for (int a = 0; a < g; a++) begin
            for (int b = a + 1; b < g; b++) begin
                if (a == j || b == j) m[idx] = 1'b1;
                idx++;
            end
        end
        m[info_bits(g) + j] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/ft2_encoder.sv
module ft2_encoder
    import ft2_pkg::*;
#(
    parameter int G = 6,
    localparam int N = G * (G - 1) / 2,
    localparam int W = N + G
) (
    input  logic [N-1:0] data,
    output logic [G-1:0] check
);
    for (genvar j = 0; j < G; j++) begin : g_chk
        localparam logic [W-1:0] GM = W'(group_cols(G, j));
        assign check[j] = ^(data & GM[N-1:0]);
    end
endmodule

// File: rtl/ft2_syndrome.sv
module ft2_syndrome
    import ft2_pkg::*;
#(
    parameter int G = 6,
    localparam int N = G * (G - 1) / 2,
    localparam int W = N + G
) (
    input  logic [W-1:0] word,
    output logic [G-1:0] syn
);
    for (genvar j = 0; j < G; j++) begin : g_syn
        localparam logic [W-1:0] GM = W'(group_cols(G, j));
        assign syn[j] = ^(word & GM);
    end
endmodule

// File: rtl/ft2_peel_step.sv
module ft2_peel_step
    import ft2_pkg::*;
#(
    parameter int G = 6,
    localparam int N = G * (G - 1) / 2,
    localparam int W = N + G
) (
    input  logic [W-1:0] word,   // erased positions hold 0
    input  logic [W-1:0] mask,
    output peel_res_t    res,
    output logic [W-1:0] clr     // one-hot position to restore
);
    logic [W-1:0] em [G];
    logic [G-1:0] single;
    logic [G-1:0] par;

    for (genvar j = 0; j < G; j++) begin : g_grp
        localparam logic [W-1:0] GM = W'(group_cols(G, j));
        assign em[j]     = mask & GM;
        assign single[j] = (em[j] != '0) && ((em[j] & (em[j] - W'(1))) == '0);
        assign par[j]    = ^(word & GM);
    end

    always_comb begin
        res.found   = 1'b0;
        res.fix_val = 1'b0;
        clr         = '0;
        for (int j = G - 1; j >= 0; j--) begin
            if (single[j]) begin
                res.found   = 1'b1;
                res.fix_val = par[j];
                clr         = em[j];
            end
        end
    end
endmodule

// File: rtl/ft2_codec.sv
module ft2_codec
    import ft2_pkg::*;
#(
    parameter int G = 6,
    localparam int N = G * (G - 1) / 2,
    localparam int W = N + G
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] enc_data,
    output logic [G-1:0] enc_check,
    input  logic         dec_start,
    input  logic         dec_check_only,
    input  logic [W-1:0] dec_word,
    input  logic [W-1:0] dec_erase,
    output logic         dec_busy,
    output logic         dec_done,
    output logic         dec_fail,
    output logic [W-1:0] dec_word_out,
    output logic [W-1:0] dec_unresolved,
    output logic [G-1:0] dec_syndrome
);
    dec_state_e   state_q;
    logic [W-1:0] word_q;
    logic [W-1:0] mask_q;
    logic         done_q;
    logic         fail_q;
    peel_res_t    step;
    logic [W-1:0] step_clr;

    ft2_encoder #(.G(G)) u_enc (
        .data  (enc_data),
        .check (enc_check)
    );

    ft2_syndrome #(.G(G)) u_syn (
        .word (word_q),
        .syn  (dec_syndrome)
    );

    ft2_peel_step #(.G(G)) u_peel (
        .word (word_q),
        .mask (mask_q),
        .res  (step),
        .clr  (step_clr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            word_q  <= '0;
            mask_q  <= '0;
            done_q  <= 1'b0;
            fail_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (dec_start) begin
                        fail_q <= 1'b0;
                        if (dec_check_only) begin
                            word_q <= dec_word;
                            mask_q <= '0;
                            done_q <= 1'b1;
                        end else begin
                            word_q  <= dec_word & ~dec_erase;
                            mask_q  <= dec_erase;
                            state_q <= ST_PEEL;
                        end
                    end
                end
                ST_PEEL: begin
                    if (mask_q == '0) begin
                        done_q  <= 1'b1;
                        state_q <= ST_IDLE;
                    end else if (step.found) begin
                        word_q <= word_q | (step.fix_val ? step_clr : '0);
                        mask_q <= mask_q & ~step_clr;
                    end else begin
                        done_q  <= 1'b1;
                        fail_q  <= 1'b1;
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign dec_busy       = (state_q == ST_PEEL);
    assign dec_done       = done_q;
    assign dec_fail       = fail_q;
    assign dec_word_out   = word_q;
    assign dec_unresolved = mask_q;
endmodule

// File: rtl/ft2_codec_chk.sv
module ft2_codec_chk #(
    parameter int G = 6,
    localparam int N = G * (G - 1) / 2,
    localparam int W = N + G
) (
    input logic         clk,
    input logic         rst,
    input logic         dec_start,
    input logic         dec_busy,
    input logic         dec_done,
    input logic         dec_fail,
    input logic [W-1:0] dec_word_out,
    input logic [W-1:0] dec_unresolved
);
    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!dec_busy && !dec_done && !dec_fail && dec_unresolved == '0)); // R11

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        (dec_done && !dec_start) |=> !dec_done); // R10

    AST_ONE_PER_STEP: assert property (@(posedge clk) disable iff (rst)
        dec_busy |=> (($past(dec_unresolved) & dec_unresolved) == dec_unresolved)
                  && ($countones($past(dec_unresolved)) - $countones(dec_unresolved) <= 1)); // R6

    AST_KNOWN_STABLE: assert property (@(posedge clk) disable iff (rst)
        dec_busy |=> ((($past(dec_word_out) ^ dec_word_out) & ~$past(dec_unresolved)) == '0)); // R6

    AST_FAIL_LEFT: assert property (@(posedge clk) disable iff (rst)
        (dec_done && dec_fail) |-> (dec_unresolved != '0)); // R8

    AST_OK_CLEAN: assert property (@(posedge clk) disable iff (rst)
        (dec_done && !dec_fail) |-> (dec_unresolved == '0)); // R7

    AST_NO_BUSY_DONE: assert property (@(posedge clk) disable iff (rst)
        dec_done |-> !dec_busy); // R9
endmodule

bind ft2_codec ft2_codec_chk #(.G(G)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .dec_start      (dec_start),
    .dec_busy       (dec_busy),
    .dec_done       (dec_done),
    .dec_fail       (dec_fail),
    .dec_word_out   (dec_word_out),
    .dec_unresolved (dec_unresolved)
);

// File: tb/sim_ft2_codec.sv
module sim_ft2_codec;
    localparam int G = 6;
    localparam int N = 15;
    localparam int W = 21;
    localparam int NV = 11;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] enc_data = '0;
    logic [G-1:0] enc_check;
    logic         dec_start = 1'b0;
    logic         dec_check_only = 1'b0;
    logic [W-1:0] dec_word = '0;
    logic [W-1:0] dec_erase = '0;
    logic         dec_busy, dec_done, dec_fail;
    logic [W-1:0] dec_word_out, dec_unresolved;
    logic [G-1:0] dec_syndrome;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    ft2_codec #(.G(G)) u0 (
        .clk(clk), .rst(rst), .enc_data(enc_data), .enc_check(enc_check),
        .dec_start(dec_start), .dec_check_only(dec_check_only),
        .dec_word(dec_word), .dec_erase(dec_erase), .dec_busy(dec_busy),
        .dec_done(dec_done), .dec_fail(dec_fail), .dec_word_out(dec_word_out),
        .dec_unresolved(dec_unresolved), .dec_syndrome(dec_syndrome)
    );

    // data, erase mask, expect fail, expected cycles to done, expected unresolved
    localparam logic [N-1:0] V_DATA [NV] = '{15'h1234, 15'h7FFF, 15'h2AAA, 15'h0F0F, 15'h5555,
        15'h1357, 15'h6C3A, 15'h4321, 15'h0001, 15'h3C3C, 15'h7E81};
    localparam logic [W-1:0] V_MASK [NV] = '{21'h0, 21'h1, 21'h08000, 21'h3, 21'h23,
        21'h18001, 21'h08001, 21'h01221, 21'h0801F, 21'h01023, 21'h1FFFFF};
    localparam logic V_FAIL [NV] = '{0, 0, 0, 0, 1, 1, 0, 0, 0, 1, 1};
    localparam int   V_CNT  [NV] = '{1, 2, 2, 3, 1, 1, 3, 5, 7, 2, 1};
    localparam logic [W-1:0] V_LEFT [NV] = '{21'h0, 21'h0, 21'h0, 21'h0, 21'h23,
        21'h18001, 21'h0, 21'h0, 21'h0, 21'h00023, 21'h1FFFFF};

    function automatic logic [G-1:0] ref_enc(input logic [N-1:0] d);
        logic [G-1:0] c;
        int idx;
        c = '0;
        idx = 0;
        for (int a = 0; a < G; a++)
            for (int b = a + 1; b < G; b++) begin
                if (d[idx]) begin c[a] = ~c[a]; c[b] = ~c[b]; end
                idx++;
            end
        return c;
    endfunction

    function automatic logic [G-1:0] ref_syn(input logic [W-1:0] w);
        return ref_enc(w[N-1:0]) ^ w[W-1:N];
    endfunction

    function automatic logic [W-1:0] ref_cw(input logic [N-1:0] d);
        return {ref_enc(d), d};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Issues a start, returns cycles from the sampling edge until done is seen.
    task automatic run(input logic co, input logic [W-1:0] w, input logic [W-1:0] m, output int cnt);
        @(negedge clk);
        dec_start = 1'b1; dec_check_only = co; dec_word = w; dec_erase = m;
        @(posedge clk);
        @(negedge clk);
        dec_start = 1'b0;
        cnt = 0;
        while (!dec_done && cnt < 60) begin
            @(negedge clk);
            cnt++;
        end
    endtask

    initial begin
        int cnt;
        logic [W-1:0] cw;
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(!dec_busy && !dec_done && !dec_fail, "R11", {dec_busy, dec_done, dec_fail}, 0);
        chk(dec_word_out == '0 && dec_unresolved == '0, "R11", dec_word_out, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!dec_busy && !dec_done && dec_unresolved == '0, "R11", dec_unresolved, 0);

        // Table: encoder and erasure repair
        for (int v = 0; v < NV; v++) begin
            enc_data = V_DATA[v];
            #1;
            chk(enc_check == ref_enc(V_DATA[v]), "R1", enc_check, ref_enc(V_DATA[v]));
            cw = ref_cw(V_DATA[v]);
            // R5: erased positions are presented inverted
            run(1'b0, cw ^ V_MASK[v], V_MASK[v], cnt);
            chk(cnt == V_CNT[v], V_FAIL[v] ? "R8" : "R7", cnt, V_CNT[v]);
            chk(dec_fail == V_FAIL[v], V_FAIL[v] ? "R8" : "R7", dec_fail, V_FAIL[v]);
            chk(dec_unresolved == V_LEFT[v], "R8", dec_unresolved, V_LEFT[v]);
            chk(dec_word_out == (cw & ~V_LEFT[v]), "R5", dec_word_out, cw & ~V_LEFT[v]);
            if (!V_FAIL[v])
                chk(dec_syndrome == '0, "R3", dec_syndrome, 0);
        end

        // R2 check-only with a mask present, R3 valid word
        cw = ref_cw(15'h2D4B);
        run(1'b1, cw, 21'h0F0F0, cnt);
        chk(cnt == 0 && !dec_fail, "R2", cnt, 0);
        chk(dec_word_out == cw && dec_unresolved == '0, "R2", dec_word_out, cw);
        chk(dec_syndrome == '0, "R3", dec_syndrome, 0);
        chk(!dec_busy, "R2", dec_busy, 0);

        // R10 done lasts one cycle, results held
        @(negedge clk);
        chk(!dec_done, "R10", dec_done, 0);
        repeat (3) @(negedge clk);
        chk(dec_word_out == cw, "R10", dec_word_out, cw);

        // R4 / R3 all single-bit corruptions
        for (int i = 0; i < W; i++) begin
            logic [W-1:0] e;
            e = cw ^ (W'(1) << i);
            run(1'b1, e, '0, cnt);
            chk(dec_syndrome == ref_syn(e) && dec_syndrome != '0, "R4", dec_syndrome, ref_syn(e));
        end
        // R4 a sample of two-bit corruptions
        for (int i = 0; i < W; i += 3) begin
            for (int k = i + 1; k < W; k += 4) begin
                logic [W-1:0] e;
                e = cw ^ (W'(1) << i) ^ (W'(1) << k);
                run(1'b1, e, '0, cnt);
                chk(dec_syndrome == ref_syn(e) && dec_syndrome != '0, "R4", dec_syndrome, ref_syn(e));
            end
        end

        // R9 start ignored while busy
        cw = ref_cw(15'h0001);
        @(negedge clk);
        dec_start = 1'b1; dec_check_only = 1'b0; dec_word = cw; dec_erase = 21'h0801F;
        @(negedge clk);
        chk(dec_busy, "R9", dec_busy, 1);
        dec_word = 21'h1ABCDE; dec_erase = 21'h3; dec_check_only = 1'b1;
        @(negedge clk);
        dec_start = 1'b0;
        cnt = 0;
        while (!dec_done && cnt < 60) begin
            chk(dec_busy, "R9", dec_busy, 1);
            @(negedge clk);
            cnt++;
        end
        chk(!dec_fail && dec_word_out == cw, "R9", dec_word_out, cw);
        chk(!dec_busy, "R9", dec_busy, 0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule